// File: doc/BRIEF.md
# Control Endpoint Interrupt Status Register

This block holds the CPU-visible interrupt status for the control endpoint of a USB device function. The packet engine sends it one-cycle event pulses: control OUT data stored and acknowledged, an IN token seen, and IN data sent and acknowledged by the host. Each event sets a sticky flag. The CPU clears flags by writing 0 to the bits it wants cleared. Bits written 1 keep their value. A second register holds enable bits. The enabled flags are ORed into one interrupt request line.

The block also tracks whether transmit data is valid, using a two-state machine. In state `TX_EMPTY` no data is valid: every IN token is answered with NAK and raises the IN-request flag. The `ARM` transition goes to `TX_READY` on the CPU packet-enable strobe `tx_arm`. In `TX_READY` an IN token is answered with data. The `SENT` transition returns to `TX_EMPTY` when the transmit-complete event fires. A synchronized VBUS level is shown as a live status bit in the flag register, and that bit cannot be cleared.

Register map. The flag register (`reg_sel`=0) has these bits:
- bit0: IN transmit complete
- bit1: IN request
- bit2: OUT receive complete
- bit3: VBUS (1 = connected)
- bits 7:4: reserved

The enable register (`reg_sel`=1) holds enables in bits 2:0, matching flag bits 2:0. Its bits 7:3 are reserved.

Top module: `ep0_irq_regs`

## Requirements
- R1: After reset, all flags, all enables and `irq` are 0, the machine is in `TX_EMPTY`, and `resp_nak` and `resp_data` are both 0.
- R2: An `ev_out_ack` pulse sets flag bit2, which is readable after the next rising edge.
- R3: In `TX_EMPTY`, an `ev_in_tok` pulse drives `resp_nak`=1 and `resp_data`=0 in the same cycle, and sets flag bit1 at the next edge.
- R4: After a `tx_arm` pulse (`ARM`), an `ev_in_tok` pulse drives `resp_data`=1 and `resp_nak`=0, and flag bit1 is not set.
- R5: An `ev_in_ack` pulse sets flag bit0 and takes `TX_READY` back to `TX_EMPTY` (`SENT`), so the next IN token gets NAK.
- R6: A write to the flag register clears each of bits 2:0 that is written 0. Each of those bits written 1 keeps its value.
- R7: If an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: Flag bit3 follows `vbus_raw` two rising edges after `vbus_raw` changes, and writing 0 to it has no effect.
- R9: Reserved bits (flag bits 7:4, enable bits 7:3) read 0 even after 1s are written to them.
- R10: `irq` is 1 exactly when some flag in bits 2:0 and its matching enable bit are both 1. VBUS never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_out_ack | input | 1 | OUT data stored and ACKed (pulse) |
| ev_in_tok | input | 1 | IN token for endpoint zero (pulse) |
| ev_in_ack | input | 1 | IN data sent and ACKed by host (pulse) |
| vbus_raw | input | 1 | Asynchronous VBUS level |
| tx_arm | input | 1 | CPU packet-enable strobe |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = flag register, 1 = enable register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| resp_nak | output | 1 | Answer the current IN token with NAK |
| resp_data | output | 1 | Answer the current IN token with data |

## Verification
The assertions assume that the event inputs are single-cycle pulses from a synchronous packet engine. They also assume `ev_in_ack` only follows a data response, and that `vbus_raw` is the only asynchronous input. The bench drives every input on the falling edge, one pulse at a time, except in the set-versus-clear scenario, where the collision is deliberate. It sends the transmit-complete pulse only after a token has been answered with data, and it holds `vbus_raw` steady for several cycles around each check.

// File: rtl/ep0_irq_pkg.sv
package ep0_irq_pkg;
    localparam int NUM_FLAGS   = 3;
    localparam int FLG_IN_DONE = 0;
    localparam int FLG_IN_REQ  = 1;
    localparam int FLG_OUT_DONE = 2;
    localparam int VBUS_BIT    = 3;
    localparam logic REG_FLAGS  = 1'b0;
    localparam logic REG_ENABLE = 1'b1;

    typedef enum logic {
        TX_EMPTY = 1'b0,
        TX_READY = 1'b1
    } tx_state_e;
endpackage

// File: rtl/ep0_vbus_sync.sv
module ep0_vbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ep0_flag_bank.sv
module ep0_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic q;
        // a set event in the same cycle overrides a clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= 1'b0;
            else if (set_i[i]) q <= 1'b1;
            else if (clr_i[i]) q <= 1'b0;
        end
        assign flag_o[i] = q;
    end
endmodule

// File: rtl/ep0_tx_ctrl.sv
module ep0_tx_ctrl
    import ep0_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_arm,
    input  logic ev_in_tok,
    input  logic ev_in_ack,
    output logic resp_nak,
    output logic resp_data,
    output logic req_set
);
    tx_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_EMPTY: if (tx_arm)    state_d = TX_READY;   // ARM
            TX_READY: if (ev_in_ack) state_d = TX_EMPTY;   // SENT
            default:                 state_d = TX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        resp_nak  = 1'b0;
        resp_data = 1'b0;
        req_set   = 1'b0;
        unique case (state_q)
            TX_EMPTY: begin
                resp_nak = ev_in_tok;
                req_set  = ev_in_tok;
            end
            TX_READY: resp_data = ev_in_tok;
            default: ;
        endcase
    end
endmodule

// File: rtl/ep0_irq_regs.sv
module ep0_irq_regs
    import ep0_irq_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_out_ack,
    input  logic             ev_in_tok,
    input  logic             ev_in_ack,
    input  logic             vbus_raw,
    input  logic             tx_arm,
    input  logic             wr_en,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq,
    output logic             resp_nak,
    output logic             resp_data
);
    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_FLAGS-1:0] en_q;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic                 req_set;
    logic                 vbus_sync;
    logic                 unused_wr_hi;

    assign unused_wr_hi = ^wr_data[REG_W-1:NUM_FLAGS];

    ep0_vbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(vbus_raw), .dout(vbus_sync)
    );

    ep0_tx_ctrl u_tx (
        .clk(clk), .rst_n(rst_n), .tx_arm(tx_arm),
        .ev_in_tok(ev_in_tok), .ev_in_ack(ev_in_ack),
        .resp_nak(resp_nak), .resp_data(resp_data), .req_set(req_set)
    );

    always_comb begin
        flag_set               = '0;
        flag_set[FLG_IN_DONE]  = ev_in_ack;
        flag_set[FLG_IN_REQ]   = req_set;
        flag_set[FLG_OUT_DONE] = ev_out_ack;
        flag_clr = (wr_en && reg_sel == REG_FLAGS) ? ~wr_data[NUM_FLAGS-1:0] : '0;
    end

    ep0_flag_bank #(.N(NUM_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr), .flag_o(flag_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           en_q <= '0;
        else if (wr_en && reg_sel == REG_ENABLE) en_q <= wr_data[NUM_FLAGS-1:0];
    end

    always_comb begin
        rd_data = '0;
        if (reg_sel == REG_FLAGS) begin
            rd_data[NUM_FLAGS-1:0] = flag_q;
            rd_data[VBUS_BIT]      = vbus_sync;
        end else begin
            rd_data[NUM_FLAGS-1:0] = en_q;
        end
    end

    assign irq = |(flag_q & en_q);
endmodule

// File: rtl/ep0_irq_chk.sv
module ep0_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_out_ack,
    input logic       ev_in_tok,
    input logic       ev_in_ack,
    input logic       wr_en,
    input logic       reg_sel,
    input logic [7:0] wr_data,
    input logic [2:0] flags,
    input logic [2:0] en,
    input logic       irq,
    input logic       resp_nak,
    input logic       resp_data
);
    AST_OUT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ev_out_ack |=> flags[2]); // R2
    AST_NAK_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        resp_nak |=> flags[1]); // R3
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_nak, resp_data})); // R4
    AST_RESP_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_nak || resp_data) |-> ev_in_tok); // R3
    AST_ACK_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_in_ack |=> flags[0]); // R5
    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && !wr_data[2] && !ev_out_ack) |=> !flags[2]); // R6
    AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && wr_data[2] && !ev_out_ack) |=> flags[2] == $past(flags[2])); // R6
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && !wr_data[0] && ev_in_ack) |=> flags[0]); // R7
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en != 3'b000 && flags != 3'b000)); // R10
endmodule

bind ep0_irq_regs ep0_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ev_out_ack(ev_out_ack), .ev_in_tok(ev_in_tok),
    .ev_in_ack(ev_in_ack), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
    .flags(flag_q), .en(en_q), .irq(irq), .resp_nak(resp_nak), .resp_data(resp_data)
);

// File: tb/tb_ep0_irq_regs.sv
`timescale 1ns/1ps
module tb_ep0_irq_regs;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       ev_out_ack = 0, ev_in_tok = 0, ev_in_ack = 0;
    logic       vbus_raw = 0, tx_arm = 0, wr_en = 0, reg_sel = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       irq, resp_nak, resp_data;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ep0_irq_regs dut (
        .clk(clk), .rst_n(rst_n), .ev_out_ack(ev_out_ack), .ev_in_tok(ev_in_tok),
        .ev_in_ack(ev_in_ack), .vbus_raw(vbus_raw), .tx_arm(tx_arm), .wr_en(wr_en),
        .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
        .resp_nak(resp_nak), .resp_data(resp_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1;
        v = rd_data;
    endtask

    // one clock with given strobes, inputs driven after the falling edge
    task automatic cyc(input logic oa, input logic it, input logic ia, input logic arm,
                       input logic we, input logic sel, input logic [7:0] d);
        ev_out_ack = oa; ev_in_tok = it; ev_in_ack = ia; tx_arm = arm;
        wr_en = we; reg_sel = sel; wr_data = d;
        @(negedge clk);
        ev_out_ack = 0; ev_in_tok = 0; ev_in_ack = 0; tx_arm = 0; wr_en = 0; wr_data = 0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd(0, v); chk("R1 flags", v, 8'h00);
        rd(1, v); chk("R1 enables", v, 8'h00);
        chk("R1 irq/resp", {5'b0, irq, resp_nak, resp_data}, 8'h00);
    endtask

    task automatic t_out_and_clear;
        logic [7:0] v;
        cyc(1, 0, 0, 0, 0, 0, 0);
        rd(0, v); chk("R2 out flag", v, 8'h04);
        cyc(0, 0, 0, 0, 1, 0, 8'hFF);
        rd(0, v); chk("R6 write ones keep", v, 8'h04);
        cyc(0, 0, 0, 0, 1, 0, 8'h00);
        rd(0, v); chk("R6 write zero clears", v, 8'h00);
    endtask

    task automatic t_nak_path;
        logic [7:0] v;
        ev_in_tok = 1; #1;
        chk("R3 nak response", {6'b0, resp_nak, resp_data}, 8'h02);
        @(negedge clk); ev_in_tok = 0;
        rd(0, v); chk("R3 req flag", v, 8'h02);
        cyc(0, 0, 0, 0, 1, 0, 8'hFD);
        rd(0, v); chk("R6 clear req", v, 8'h00);
    endtask

    task automatic t_data_path;
        logic [7:0] v;
        cyc(0, 0, 0, 1, 0, 0, 0);
        ev_in_tok = 1; #1;
        chk("R4 data response", {6'b0, resp_nak, resp_data}, 8'h01);
        @(negedge clk); ev_in_tok = 0;
        rd(0, v); chk("R4 no req flag", v, 8'h00);
        cyc(0, 0, 1, 0, 0, 0, 0);
        rd(0, v); chk("R5 done flag", v, 8'h01);
        ev_in_tok = 1; #1;
        chk("R5 back to nak", {6'b0, resp_nak, resp_data}, 8'h02);
        @(negedge clk); ev_in_tok = 0;
        cyc(0, 0, 0, 0, 1, 0, 8'h00);
    endtask

    task automatic t_collision;
        logic [7:0] v;
        cyc(0, 0, 1, 0, 1, 0, 8'h00);
        rd(0, v); chk("R7 set wins", v, 8'h01);
        cyc(0, 0, 0, 0, 1, 0, 8'h00);
    endtask

    task automatic t_irq_reserved;
        logic [7:0] v;
        cyc(0, 0, 0, 0, 1, 1, 8'hFA);
        rd(1, v); chk("R9 enable reserved", v, 8'h02);
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R10 irq masked", {7'b0, irq}, 8'h00);
        cyc(0, 0, 0, 0, 1, 1, 8'h04);
        chk("R10 irq enabled", {7'b0, irq}, 8'h01);
        cyc(0, 0, 0, 0, 1, 0, 8'hF0);
        rd(0, v); chk("R9 flag reserved", v, 8'h00);
        chk("R10 irq cleared", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_vbus;
        logic [7:0] v;
        cyc(0, 0, 0, 0, 1, 1, 8'h07);
        vbus_raw = 1;
        @(negedge clk);
        rd(0, v); chk("R8 vbus one edge", v, 8'h00);
        @(negedge clk);
        rd(0, v); chk("R8 vbus two edges", v, 8'h08);
        chk("R10 vbus no irq", {7'b0, irq}, 8'h00);
        cyc(0, 0, 0, 0, 1, 0, 8'h00);
        rd(0, v); chk("R8 vbus not clearable", v, 8'h08);
        vbus_raw = 0;
        repeat (2) @(negedge clk);
        rd(0, v); chk("R8 vbus low", v, 8'h00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_out_and_clear();
        t_nak_path();
        t_data_path();
        t_collision();
        t_irq_reserved();
        t_vbus();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule